// File: doc/BRIEF.md
# Eight-Bit Execution Datapath with Result Bypass

This block is the execute stage of a small 8-bit integer machine. Each cycle in which `in_valid` is high it takes one instruction, picks its two operands, runs one ALU operation, and registers the result. Each operand comes from one of three places: a register of the 32-entry register file, an 8-bit immediate carried in the instruction, or the bypass latch. The bypass latch holds the result of the most recent executed instruction.

Writeback is optional. With `wr_en` low the result goes only into the bypass latch, so a chain of instructions can pass an intermediate value forward without using a register. The operation set has wrapping add and subtract, plain and inverted logic, a signed set-less-than, and three shifts. The shifts take operand A and a separate shift-amount field. A shift by zero copies operand A through unchanged, which serves as a move or load-immediate.

The registered result and a one-cycle valid pulse are the block's only outputs. Register contents are read by executing a zero shift of a register operand.

Top module: `alu8_bypass_dp`

## Requirements
- R1: After reset, `res_o` is 0, `res_valid_o` is 0, and every register of the file reads 0.
- R2: Operand select encoding applies to each operand on its own: 2'b00 reads the register named by the operand's register field, 2'b01 takes the operand's immediate, and 2'b10 or 2'b11 takes the bypass latch, which holds the result of the previous executed instruction.
- R3: Opcode 0 gives A+B and opcode 1 gives A-B, both modulo 256. For example, 19-255=20 and 249+15+15=23.
- R4: Logic opcodes: 2 gives A or B, 3 gives A xor B, 4 gives not(A and B), 5 gives not(A or B), and 6 gives not(A xor B). For example, 16 xnor 254 = 17 and 0xFD nand 0xEF = 18.
- R5: Opcode 7 compares A and B as signed 8-bit values and gives 1 if A<B, otherwise 0. For example, 255<0 gives 1, 0<255 gives 0, and 2<3 gives 1.
- R6: Opcodes 8, 9 and 10 shift operand A by the 3-bit `in_shamt`: 8 shifts left, 9 shifts right logically, and 10 shifts right arithmetically. Operand B has no effect, and a shift by 0 returns A. For example, 60>>2=15, 128>>>2=0xE0 and 208>>>4=0xFD.
- R7: Opcodes 11 to 15 give a result of 0.
- R8: With `wr_en` high, the result is written to register `wr_dst` at the clock edge and is read by the next instruction. Register 0 is writable like any other register. With `wr_en` low, no register changes.
- R9: On every valid instruction, whatever `wr_en` is, the result is loaded into the bypass latch. It appears on `res_o` from the cycle after the instruction, and `res_valid_o` is high for that one cycle.
- R10: While `in_valid` is low, `res_o` holds its value, `res_valid_o` is 0, and no register is written, whatever the other inputs are.
- R11: An instruction that reads the register it writes sees the value the register held before that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 4 | Operation code |
| a_sel | input | 2 | Operand A source select |
| a_reg | input | 5 | Operand A register index |
| a_imm | input | 8 | Operand A immediate |
| b_sel | input | 2 | Operand B source select |
| b_reg | input | 5 | Operand B register index |
| b_imm | input | 8 | Operand B immediate |
| in_shamt | input | 3 | Shift amount for opcodes 8 to 10 |
| wr_en | input | 1 | Write the result to the register file |
| wr_dst | input | 5 | Destination register |
| res_o | output | 8 | Bypass latch: last executed result |
| res_valid_o | output | 1 | One-cycle pulse after each executed instruction |

## Verification
A wrong ALU or operand-select path shows on `res_o` one cycle after the instruction that caused it. A corrupted register file or bypass latch stays hidden until a later instruction reads that register, or selects the bypass. For that reason the sweeps feed results back through bypass and register operands, and every register is read back after it is written. A missed or spurious update of the bypass latch shows at once as a wrong `res_o` or `res_valid_o` in the idle cycles.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   localparam int OP_W  = 4;
   localparam int SEL_W = 2;

   typedef logic [OP_W-1:0]  op_t;
   typedef logic [SEL_W-1:0] sel_t;

   localparam op_t OP_ADD  = 4'd0;
   localparam op_t OP_SUB  = 4'd1;
   localparam op_t OP_OR   = 4'd2;
   localparam op_t OP_XOR  = 4'd3;
   localparam op_t OP_NAND = 4'd4;
   localparam op_t OP_NOR  = 4'd5;
   localparam op_t OP_XNOR = 4'd6;
   localparam op_t OP_SLT  = 4'd7;
   localparam op_t OP_SLL  = 4'd8;
   localparam op_t OP_SRL  = 4'd9;
   localparam op_t OP_SRA  = 4'd10;

   localparam sel_t SEL_REG = 2'b00;
   localparam sel_t SEL_IMM = 2'b01;

   function automatic logic is_shift(input op_t op);
      return (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
   endfunction
endpackage

// File: rtl/alu8_regfile.sv
module alu8_regfile #(
   parameter int DATA_W     = 8,
   parameter int NREG       = 32,
   parameter bit RESET_REGS = 1'b1,
   localparam int AW        = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     rd_a_addr,
   input  logic [AW-1:0]     rd_b_addr,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b,
   input  logic              we,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] mem [NREG];

   if (NREG < 2 || NREG != (1 << AW)) begin : g_bad_depth
      $error("alu8_regfile: NREG must be a power of two and at least 2");
   end

   if (RESET_REGS) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
         end else if (we) begin
            mem[wr_addr] <= wr_data;
         end
      end
   end else begin : g_norst
      always_ff @(posedge clk) begin
         if (we) mem[wr_addr] <= wr_data;
      end
   end

   assign rd_a = mem[rd_a_addr];
   assign rd_b = mem[rd_b_addr];

   // R8: a write lands in the addressed entry at the edge
   a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/alu8_opnd_mux.sv
module alu8_opnd_mux
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  sel_t              sel,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [DATA_W-1:0] imm,
   input  logic [DATA_W-1:0] byp,
   output logic [DATA_W-1:0] opnd
);
   always_comb begin
      case (sel)
         SEL_REG: opnd = rf_val;
         SEL_IMM: opnd = imm;
         default: opnd = byp;
      endcase
   end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SH_W   = 3,
   parameter bit BARREL = 1'b1
) (
   input  op_t               op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [SH_W-1:0]   sh,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] sll_v, srl_v, sra_v;
   logic              lt;

   if (DATA_W < 2) begin : g_bad_w
      $error("alu8_core: DATA_W must be at least 2");
   end
   if ((1 << SH_W) > DATA_W) begin : g_bad_sh
      $error("alu8_core: shift field wider than the data needs");
   end

   if (BARREL) begin : g_barrel
      logic [DATA_W-1:0] sl [SH_W+1];
      logic [DATA_W-1:0] sr [SH_W+1];
      logic [DATA_W-1:0] sa [SH_W+1];
      assign sl[0] = a;
      assign sr[0] = a;
      assign sa[0] = a;
      for (genvar k = 0; k < SH_W; k++) begin : g_stage
         assign sl[k+1] = sh[k] ? (sl[k] << (1 << k)) : sl[k];
         assign sr[k+1] = sh[k] ? (sr[k] >> (1 << k)) : sr[k];
         assign sa[k+1] = sh[k] ? DATA_W'($signed(sa[k]) >>> (1 << k)) : sa[k];
      end
      assign sll_v = sl[SH_W];
      assign srl_v = sr[SH_W];
      assign sra_v = sa[SH_W];
   end else begin : g_flat
      assign sll_v = a << sh;
      assign srl_v = a >> sh;
      assign sra_v = DATA_W'($signed(a) >>> sh);
   end

   assign lt = $signed(a) < $signed(b);

   always_comb begin
      case (op)
         OP_ADD:  res = a + b;
         OP_SUB:  res = a - b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_NAND: res = ~(a & b);
         OP_NOR:  res = ~(a | b);
         OP_XNOR: res = ~(a ^ b);
         OP_SLT:  res = {{(DATA_W-1){1'b0}}, lt};
         OP_SLL:  res = sll_v;
         OP_SRL:  res = srl_v;
         OP_SRA:  res = sra_v;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/alu8_bypass_dp.sv
module alu8_bypass_dp
   import alu8_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NREG       = 32,
   parameter int SH_W       = 3,
   parameter bit RESET_REGS = 1'b1,
   parameter bit BARREL     = 1'b1,
   localparam int AW        = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        in_op,
   input  logic [1:0]        a_sel,
   input  logic [AW-1:0]     a_reg,
   input  logic [DATA_W-1:0] a_imm,
   input  logic [1:0]        b_sel,
   input  logic [AW-1:0]     b_reg,
   input  logic [DATA_W-1:0] b_imm,
   input  logic [SH_W-1:0]   in_shamt,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_dst,
   output logic [DATA_W-1:0] res_o,
   output logic              res_valid_o
);
   logic [DATA_W-1:0] rf_a, rf_b, opa, opb, alu_res, byp_q;
   logic              rf_we;
   logic              vld_q;

   assign rf_we = in_valid & wr_en;

   alu8_regfile #(.DATA_W(DATA_W), .NREG(NREG), .RESET_REGS(RESET_REGS)) rf_i (
      .clk(clk), .rst_n(rst_n),
      .rd_a_addr(a_reg), .rd_b_addr(b_reg),
      .rd_a(rf_a), .rd_b(rf_b),
      .we(rf_we), .wr_addr(wr_dst), .wr_data(alu_res)
   );

   alu8_opnd_mux #(.DATA_W(DATA_W)) mux_a_i (
      .sel(a_sel), .rf_val(rf_a), .imm(a_imm), .byp(byp_q), .opnd(opa)
   );

   alu8_opnd_mux #(.DATA_W(DATA_W)) mux_b_i (
      .sel(b_sel), .rf_val(rf_b), .imm(b_imm), .byp(byp_q), .opnd(opb)
   );

   alu8_core #(.DATA_W(DATA_W), .SH_W(SH_W), .BARREL(BARREL)) alu_i (
      .op(in_op), .a(opa), .b(opb), .sh(in_shamt), .res(alu_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) byp_q <= alu_res;
      end
   end

   assign res_o       = byp_q;
   assign res_valid_o = vld_q;

   // R10: idle cycles leave the latch alone and raise no pulse
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(res_o) && !res_valid_o);

   // R9: each executed instruction gives a pulse
   a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid_o);

   // R9: latch and written register agree after a writeback
   a_r9_latch_matches_rf: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> res_o == rf_i.mem[$past(wr_dst)]);

   // R5: compare result is boolean
   a_r5_slt_bool: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == OP_SLT) |=> res_o[DATA_W-1:1] == '0);

   // R6: zero shift passes operand A
   a_r6_zero_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_shift(in_op) && in_shamt == '0) |=> res_o == $past(opa));

   // R7: unassigned opcodes give zero
   a_r7_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op > OP_SRA) |=> res_o == '0);
endmodule

// File: tb/alu8_bypass_dp_tb.sv
`timescale 1ns/1ps
module alu8_bypass_dp_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [3:0] in_op = '0;
   logic [1:0] a_sel = '0, b_sel = '0;
   logic [4:0] a_reg = '0, b_reg = '0, wr_dst = '0;
   logic [7:0] a_imm = '0, b_imm = '0;
   logic [2:0] in_shamt = '0;
   logic       wr_en = 1'b0;
   logic [7:0] res_o;
   logic       res_valid_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] mregs [32];
   logic [7:0] mbyp;

   always #5 clk = ~clk;

   alu8_bypass_dp dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .a_sel(a_sel), .a_reg(a_reg), .a_imm(a_imm),
      .b_sel(b_sel), .b_reg(b_reg), .b_imm(b_imm),
      .in_shamt(in_shamt), .wr_en(wr_en), .wr_dst(wr_dst),
      .res_o(res_o), .res_valid_o(res_valid_o)
   );

   function automatic logic [7:0] bench_alu(input logic [3:0] op, input logic [7:0] a,
                                            input logic [7:0] b, input logic [2:0] sh);
      int ia, ib, r;
      ia = (a > 127) ? int'(a) - 256 : int'(a);
      ib = (b > 127) ? int'(b) - 256 : int'(b);
      case (op)
         4'd0: r = (int'(a) + int'(b)) % 256;
         4'd1: r = (int'(a) - int'(b) + 256) % 256;
         4'd2: r = int'(a | b);
         4'd3: r = int'(a ^ b);
         4'd4: r = 255 - int'(a & b);
         4'd5: r = 255 - int'(a | b);
         4'd6: r = 255 - int'(a ^ b);
         4'd7: r = (ia < ib) ? 1 : 0;
         4'd8: r = (int'(a) * (1 << sh)) % 256;
         4'd9: r = int'(a) / (1 << sh);
         4'd10: begin
            r = ia;
            for (int k = 0; k < int'(sh); k++) r = (r < 0) ? -((-r + 1) / 2) : r / 2;
            r = (r + 256) % 256;
         end
         default: r = 0;
      endcase
      return r[7:0];
   endfunction

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   function automatic logic [7:0] pick(input logic [1:0] s, input logic [4:0] r, input logic [7:0] i);
      if (s == 2'b00) return mregs[r];
      if (s == 2'b01) return i;
      return mbyp;
   endfunction

   task automatic exec(input string req, input logic [3:0] op,
                       input logic [1:0] as, input logic [4:0] ar, input logic [7:0] ai,
                       input logic [1:0] bs, input logic [4:0] br, input logic [7:0] bi,
                       input logic [2:0] sh, input logic we, input logic [4:0] dst);
      logic [7:0] exp;
      exp = bench_alu(op, pick(as, ar, ai), pick(bs, br, bi), sh);
      in_valid = 1'b1; in_op = op;
      a_sel = as; a_reg = ar; a_imm = ai;
      b_sel = bs; b_reg = br; b_imm = bi;
      in_shamt = sh; wr_en = we; wr_dst = dst;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (we) mregs[dst] = exp;
      mbyp = exp;
      checks++;
      if (res_o !== exp || res_valid_o !== 1'b1) begin
         failures++;
         $display("FAIL %s: actual=%0d/v%0b expected=%0d/v1", req, res_o, res_valid_o, exp);
      end
   endtask

   task automatic rd(input string req, input logic [4:0] r);
      exec(req, 4'd8, 2'b00, r, 8'd0, 2'b01, 5'd0, 8'd0, 3'd0, 1'b0, 5'd0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      string req;
      for (int i = 0; i < 32; i++) mregs[i] = '0;
      mbyp = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 res", res_o, 8'd0);
      check("R1 valid", {7'd0, res_valid_o}, 8'd0);
      for (int i = 0; i < 32; i++) rd("R1 reg read", 5'(i));

      // R8: fill every register including r0, then read back
      for (int i = 0; i < 32; i++)
         exec("R8 write", 4'd8, 2'b01, 5'd0, 8'(i * 7 + 3), 2'b01, 5'd0, 8'd0, 3'd0, 1'b1, 5'(i));
      for (int i = 0; i < 32; i++) begin
         rd("R8 readback", 5'(i));
         check("R8 readback value", res_o, 8'(i * 7 + 3));
      end
      // R8: no write when wr_en low
      exec("R8 nowrite", 4'd8, 2'b01, 5'd0, 8'h99, 2'b01, 5'd0, 8'd0, 3'd0, 1'b0, 5'd5);
      rd("R8 unchanged", 5'd5);
      check("R8 unchanged value", res_o, 8'd38);
      // R11: read-before-write of the same register
      exec("R11 rmw", 4'd0, 2'b00, 5'd5, 8'd0, 2'b01, 5'd0, 8'd1, 3'd0, 1'b1, 5'd5);
      check("R11 rmw value", res_o, 8'd39);
      rd("R11 after", 5'd5);
      check("R11 after value", res_o, 8'd39);

      // R3..R6, R9, R2: worked examples through the bypass
      exec("R3", 4'd8, 2'b01, 5'd0, 8'd10, 2'b01, 5'd0, 8'd0, 3'd1, 1'b0, 5'd0);
      exec("R3", 4'd1, 2'b10, 5'd0, 8'd0, 2'b01, 5'd0, 8'd1, 3'd0, 1'b0, 5'd0);
      exec("R3", 4'd1, 2'b11, 5'd0, 8'd0, 2'b01, 5'd0, 8'd255, 3'd0, 1'b0, 5'd0);
      check("R3 19-255", res_o, 8'd20);
      exec("R3", 4'd8, 2'b01, 5'd0, 8'd249, 2'b01, 5'd0, 8'd0, 3'd0, 1'b0, 5'd0);
      exec("R3", 4'd0, 2'b10, 5'd0, 8'd0, 2'b01, 5'd0, 8'd15, 3'd0, 1'b0, 5'd0);
      exec("R3", 4'd0, 2'b10, 5'd0, 8'd0, 2'b01, 5'd0, 8'd15, 3'd0, 1'b0, 5'd0);
      check("R3 249+15+15", res_o, 8'd23);
      exec("R4", 4'd6, 2'b01, 5'd0, 8'd16, 2'b01, 5'd0, 8'd254, 3'd0, 1'b0, 5'd0);
      check("R4 xnor", res_o, 8'd17);
      exec("R6", 4'd10, 2'b01, 5'd0, 8'd208, 2'b01, 5'd0, 8'd0, 3'd4, 1'b0, 5'd0);
      check("R6 sra 4", res_o, 8'hFD);
      exec("R4", 4'd4, 2'b10, 5'd0, 8'd0, 2'b01, 5'd0, 8'hEF, 3'd0, 1'b0, 5'd0);
      check("R4 nand", res_o, 8'd18);
      exec("R6", 4'd10, 2'b01, 5'd0, 8'd128, 2'b01, 5'd0, 8'd0, 3'd2, 1'b0, 5'd0);
      check("R6 sra 2", res_o, 8'hE0);
      exec("R6", 4'd9, 2'b01, 5'd0, 8'd60, 2'b01, 5'd0, 8'd0, 3'd2, 1'b0, 5'd0);
      check("R6 srl", res_o, 8'd15);
      exec("R5", 4'd7, 2'b01, 5'd0, 8'd255, 2'b01, 5'd0, 8'd0, 3'd0, 1'b0, 5'd0);
      check("R5 255<0", res_o, 8'd1);
      exec("R5", 4'd7, 2'b01, 5'd0, 8'd0, 2'b01, 5'd0, 8'd255, 3'd0, 1'b0, 5'd0);
      check("R5 0<255", res_o, 8'd0);
      exec("R5", 4'd7, 2'b01, 5'd0, 8'd2, 2'b01, 5'd0, 8'd3, 3'd0, 1'b0, 5'd0);
      check("R5 2<3", res_o, 8'd1);
      // R9: shift chain carried only by the bypass, written at the end
      exec("R9", 4'd8, 2'b01, 5'd0, 8'd1, 2'b01, 5'd0, 8'd0, 3'd1, 1'b0, 5'd0);
      for (int k = 0; k < 3; k++)
         exec("R9", 4'd8, 2'b10, 5'd0, 8'd0, 2'b01, 5'd0, 8'd0, 3'd1, k == 2, 5'd16);
      check("R9 chain", res_o, 8'd16);
      rd("R9 written", 5'd16);

      // R10: idle cycles with busy inputs
      in_op = 4'd0; a_sel = 2'b01; a_imm = 8'd77; wr_en = 1'b1; wr_dst = 5'd7;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk);
         @(negedge clk);
         check("R10 hold", res_o, mbyp);
         check("R10 no pulse", {7'd0, res_valid_o}, 8'd0);
      end
      wr_en = 1'b0;
      rd("R10 reg untouched", 5'd7);
      check("R10 reg value", res_o, 8'd52);

      // R2..R7: sweep of every opcode over all A values with mixed sources
      for (int op = 0; op < 16; op++) begin
         if (op < 2) req = "R3";
         else if (op < 7) req = "R4";
         else if (op == 7) req = "R5";
         else if (op < 11) req = "R6";
         else req = "R7";
         for (int a = 0; a < 256; a++) begin
            for (int j = 0; j < 16; j++) begin
               logic [1:0] as, bs;
               as = (j % 5 == 4) ? 2'b00 : 2'b01;
               bs = (j % 7 == 6) ? 2'b10 : ((j % 3 == 2) ? 2'b00 : 2'b01);
               exec(req, 4'(op), as, 5'(a), 8'(a), bs, 5'(j + a), 8'(a * j * 29 + j * 83),
                    3'(a + j), (j == 9), 5'(a + op));
            end
         end
      end
      // R2: final readback of every register after the sweep
      for (int i = 0; i < 32; i++) rd("R2 reg source", 5'(i));

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule